// File: doc/BRIEF.md
# Console CPU Bus Address Decoder

This block sits between a retro game console's 8-bit CPU and everything on its 16-bit address bus. Every access is sorted into one region: work RAM, the picture-processor register file, the audio/IO window, cartridge RAM, cartridge program ROM, or an unmapped hole. Mirrored regions are folded onto their physical storage by discarding upper address bits. The small work RAM and the eight-entry register file are held inside the block. The register file is a plain stub that stores and returns bytes, standing in for the real picture processor. Program ROM lives outside, behind two combinational read ports.

Read results are registered and appear one clock after the read strobe. A word-read request returns two bytes in little-endian order. Each byte is decoded independently, so a word may span two regions. A write to the DMA page address latches the written byte and emits a one-cycle trigger for an external DMA engine. Accesses to the unmapped hole, and writes into program ROM, raise an illegal-access flag one clock later.

Top module: `cpu_bus_decoder`

## Requirements
- R1: During and right after synchronous reset, `rd_valid`, `bad_access` and `dma_kick` are 0, `dma_page` is 0x00 and `rd_data` is 0x0000.
- R2: Addresses 0x0000–0x1FFF reach a 2 KiB work RAM at index `addr[10:0]`, so a byte written through any of the four mirrors reads back through every other.
- R3: Addresses 0x2000–0x3FFF reach an 8-entry, 8-bit register file at index `addr[2:0]`; writes store the byte and reads return it.
- R4: Reads in 0x4000–0x401F return 0x00 without raising `bad_access`, and writes there (other than the DMA address) change nothing that a later read can see.
- R5: A write to 0x4014 makes `dma_page` equal the written byte from the next clock. It drives `dma_kick` high for exactly that one clock. `dma_page` holds its value until the next such write.
- R6: Any read or write in 0x4020–0x5FFF sets `bad_access` in the clock after the access; a legal access clears it again.
- R7: Reads in 0x6000–0x7FFF return 0x00 and writes there are ignored; neither sets `bad_access`.
- R8: Reads in 0x8000–0xFFFF drive the ROM offset `addr[14:0]` on the ROM port. When `single_bank` is 1, offset bit 14 is forced to 0, so the upper 16 KiB mirrors the lower; the returned byte is the ROM port data.
- R9: A write in 0x8000–0xFFFF sets `bad_access` in the following clock and leaves ROM reads unchanged.
- R10: With `word_rd` high, `rd_data[7:0]` is the byte at `addr` and `rd_data[15:8]` the byte at `addr+1` (wrapping 0xFFFF to 0x0000); a byte read puts 0x00 in `rd_data[15:8]`.
- R11: `rd_valid` is high in exactly the clock after a cycle with `rd_en` high and `wr_en` low, and `rd_data` holds its value until the next such read.
- R12: When `rd_en` and `wr_en` are both high, the write takes place and the read is dropped (`rd_valid` stays 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | CPU address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| word_rd | input | 1 | Read two bytes (addr, addr+1) instead of one |
| wr_data | input | 8 | Write byte |
| single_bank | input | 1 | Cartridge holds one 16 KiB program bank |
| prg_lo_addr | output | 15 | ROM offset for the low byte |
| prg_lo_data | input | 8 | ROM byte at `prg_lo_addr` |
| prg_hi_addr | output | 15 | ROM offset for the high byte of a word read |
| prg_hi_data | input | 8 | ROM byte at `prg_hi_addr` |
| rd_data | output | 16 | Registered read result |
| rd_valid | output | 1 | Read result valid this clock |
| bad_access | output | 1 | Previous access was unmapped or a ROM write |
| dma_kick | output | 1 | One-clock DMA trigger |
| dma_page | output | 8 | Latched DMA page byte |

## Verification
A wrong fold, such as an extra index bit in the RAM or register file, shows up as stale or unknown data on `rd_data` one clock after a read through a mirror alias. Broken region boundaries show up on `bad_access` or as non-zero stub reads one clock after the boundary address is touched. A stuck or mistimed DMA trigger appears on `dma_kick` in the clock right after the page write. Word reads are checked across a region seam and across the top-of-memory wrap, where the two byte lanes disagree about their region.

// File: rtl/cpubus_pkg.sv
package cpubus_pkg;

    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 8;
    localparam int RAM_AW   = 11;
    localparam int REG_AW   = 3;
    localparam int ROM_AW   = 15;
    localparam int LANES    = 2;

    localparam logic [ADDR_W-1:0] PREG_BASE  = 16'h2000;
    localparam logic [ADDR_W-1:0] IO_BASE    = 16'h4000;
    localparam logic [ADDR_W-1:0] HOLE_BASE  = 16'h4020;
    localparam logic [ADDR_W-1:0] CRAM_BASE  = 16'h6000;
    localparam logic [ADDR_W-1:0] PROM_BASE  = 16'h8000;
    localparam logic [ADDR_W-1:0] DMA_ADDR   = 16'h4014;

    typedef enum logic [2:0] {
        RG_WRAM = 3'd0,
        RG_PREG = 3'd1,
        RG_IO   = 3'd2,
        RG_HOLE = 3'd3,
        RG_CRAM = 3'd4,
        RG_PROM = 3'd5
    } region_e;

    typedef struct packed {
        region_e             region;
        logic [RAM_AW-1:0]   ram_idx;
        logic [REG_AW-1:0]   reg_idx;
        logic [ROM_AW-1:0]   rom_off;
    } lane_dec_t;

    function automatic region_e classify(input logic [ADDR_W-1:0] a);
        region_e r;
        if (a < PREG_BASE)      r = RG_WRAM;
        else if (a < IO_BASE)   r = RG_PREG;
        else if (a < HOLE_BASE) r = RG_IO;
        else if (a < CRAM_BASE) r = RG_HOLE;
        else if (a < PROM_BASE) r = RG_CRAM;
        else                    r = RG_PROM;
        return r;
    endfunction

    function automatic logic [ROM_AW-1:0] rom_fold(input logic [ADDR_W-1:0] a,
                                                   input logic one_bank);
        logic [ROM_AW-1:0] off;
        off = a[ROM_AW-1:0];
        if (one_bank) off[ROM_AW-1] = 1'b0;
        return off;
    endfunction

endpackage

// File: rtl/bus_lane_decode.sv
module bus_lane_decode
    import cpubus_pkg::*;
(
    input  logic [ADDR_W-1:0] lane_addr,
    input  logic              one_bank,
    output lane_dec_t         dec
);
    always_comb begin
        dec.region  = classify(lane_addr);
        dec.ram_idx = lane_addr[RAM_AW-1:0];
        dec.reg_idx = lane_addr[REG_AW-1:0];
        dec.rom_off = rom_fold(lane_addr, one_bank);
    end
endmodule

// File: rtl/work_ram.sv
module work_ram #(
    parameter int AW = 11,
    parameter int DW = 8,
    parameter int RP = 2
) (
    input  logic                clk,
    input  logic                we,
    input  logic [AW-1:0]       waddr,
    input  logic [DW-1:0]       wdata,
    input  logic [RP*AW-1:0]    raddr,
    output logic [RP*DW-1:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    for (genvar p = 0; p < RP; p++) begin : g_rport
        assign rdata[p*DW +: DW] = mem[raddr[p*AW +: AW]];
    end
endmodule

// File: rtl/preg_stub.sv
module preg_stub #(
    parameter int AW = 3,
    parameter int DW = 8,
    parameter int RP = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [AW-1:0]       waddr,
    input  logic [DW-1:0]       wdata,
    input  logic [RP*AW-1:0]    raddr,
    output logic [RP*DW-1:0]    rdata
);
    localparam int NREG = 1 << AW;

    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NREG; k++) regs[k] <= '0;
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < RP; p++) begin : g_rport
        assign rdata[p*DW +: DW] = regs[raddr[p*AW +: AW]];
    end
endmodule

// File: rtl/cpu_bus_decoder.sv
module cpu_bus_decoder
    import cpubus_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic                 word_rd,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 single_bank,
    output logic [ROM_AW-1:0]    prg_lo_addr,
    input  logic [DATA_W-1:0]    prg_lo_data,
    output logic [ROM_AW-1:0]    prg_hi_addr,
    input  logic [DATA_W-1:0]    prg_hi_data,
    output logic [2*DATA_W-1:0]  rd_data,
    output logic                 rd_valid,
    output logic                 bad_access,
    output logic                 dma_kick,
    output logic [DATA_W-1:0]    dma_page
);
    lane_dec_t                 dec      [LANES];
    logic [DATA_W-1:0]         prg_in   [LANES];
    logic [DATA_W-1:0]         lane_byte[LANES];
    logic [LANES*RAM_AW-1:0]   ram_raddr;
    logic [LANES*DATA_W-1:0]   ram_rdata;
    logic [LANES*REG_AW-1:0]   reg_raddr;
    logic [LANES*DATA_W-1:0]   reg_rdata;

    assign prg_in[0] = prg_lo_data;
    assign prg_in[1] = prg_hi_data;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [ADDR_W-1:0] lane_addr;
        assign lane_addr = addr + ADDR_W'(i);

        bus_lane_decode u_dec (
            .lane_addr (lane_addr),
            .one_bank  (single_bank),
            .dec       (dec[i])
        );

        assign ram_raddr[i*RAM_AW +: RAM_AW] = dec[i].ram_idx;
        assign reg_raddr[i*REG_AW +: REG_AW] = dec[i].reg_idx;

        always_comb begin
            unique case (dec[i].region)
                RG_WRAM: lane_byte[i] = ram_rdata[i*DATA_W +: DATA_W];
                RG_PREG: lane_byte[i] = reg_rdata[i*DATA_W +: DATA_W];
                RG_PROM: lane_byte[i] = prg_in[i];
                default: lane_byte[i] = '0;
            endcase
        end
    end

    assign prg_lo_addr = dec[0].rom_off;
    assign prg_hi_addr = dec[1].rom_off;

    logic ram_we, reg_we, is_read, dma_hit, access_bad;

    assign is_read = rd_en && !wr_en;
    assign ram_we  = wr_en && (dec[0].region == RG_WRAM);
    assign reg_we  = wr_en && (dec[0].region == RG_PREG);
    assign dma_hit = wr_en && (addr == DMA_ADDR);

    always_comb begin
        access_bad = 1'b0;
        if (wr_en)
            access_bad = (dec[0].region == RG_HOLE) || (dec[0].region == RG_PROM);
        else if (rd_en)
            access_bad = (dec[0].region == RG_HOLE) ||
                         (word_rd && (dec[1].region == RG_HOLE));
    end

    work_ram #(.AW(RAM_AW), .DW(DATA_W), .RP(LANES)) u_wram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (dec[0].ram_idx),
        .wdata (wr_data),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    preg_stub #(.AW(REG_AW), .DW(DATA_W), .RP(LANES)) u_preg (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .waddr (dec[0].reg_idx),
        .wdata (wr_data),
        .raddr (reg_raddr),
        .rdata (reg_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data    <= '0;
            rd_valid   <= 1'b0;
            bad_access <= 1'b0;
            dma_kick   <= 1'b0;
            dma_page   <= '0;
        end else begin
            rd_valid   <= is_read;
            bad_access <= access_bad;
            dma_kick   <= dma_hit;
            if (dma_hit) dma_page <= wr_data;
            if (is_read)
                rd_data <= {(word_rd ? lane_byte[1] : {DATA_W{1'b0}}), lane_byte[0]};
        end
    end
endmodule

// File: rtl/cpu_bus_decoder_chk.sv
module cpu_bus_decoder_chk
    import cpubus_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   addr,
    input logic                rd_en,
    input logic                wr_en,
    input logic                word_rd,
    input logic [DATA_W-1:0]   wr_data,
    input logic [2*DATA_W-1:0] rd_data,
    input logic                rd_valid,
    input logic                bad_access,
    input logic                dma_kick,
    input logic [DATA_W-1:0]   dma_page
);
    p_valid_after_read_r11: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en) |=> rd_valid);

    p_no_valid_on_write_r12: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !rd_valid);

    p_kick_one_cycle_r5: assert property (@(posedge clk) disable iff (rst)
        dma_kick |=> !dma_kick);

    p_kick_page_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == DMA_ADDR) |=> (dma_kick && dma_page == $past(wr_data)));

    p_page_held_r5: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == DMA_ADDR) |=> $stable(dma_page));

    p_hole_flag_r6: assert property (@(posedge clk) disable iff (rst)
        ((rd_en || wr_en) && addr >= HOLE_BASE && addr < CRAM_BASE) |=> bad_access);

    p_rom_write_flag_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr >= PROM_BASE) |=> bad_access);

    p_io_reads_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && !word_rd && addr >= IO_BASE && addr < HOLE_BASE)
        |=> (rd_data == '0 && !bad_access));

    p_byte_read_high_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && !word_rd) |=> (rd_data[2*DATA_W-1:DATA_W] == '0));
endmodule

bind cpu_bus_decoder cpu_bus_decoder_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr       (addr),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .word_rd    (word_rd),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .bad_access (bad_access),
    .dma_kick   (dma_kick),
    .dma_page   (dma_page)
);

// File: tb/cpu_bus_decoder_tb.sv
`timescale 1ns/1ps
module cpu_bus_decoder_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] addr;
    logic        rd_en, wr_en, word_rd;
    logic [7:0]  wr_data;
    logic        single_bank;
    logic [14:0] prg_lo_addr, prg_hi_addr;
    logic [7:0]  prg_lo_data, prg_hi_data;
    logic [15:0] rd_data;
    logic        rd_valid, bad_access, dma_kick;
    logic [7:0]  dma_page;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    function automatic logic [7:0] rom_byte(input logic [14:0] off);
        return off[7:0] ^ {1'b0, off[14:8]} ^ 8'h5A;
    endfunction

    assign prg_lo_data = rom_byte(prg_lo_addr);
    assign prg_hi_data = rom_byte(prg_hi_addr);

    cpu_bus_decoder u_dut (
        .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .word_rd(word_rd), .wr_data(wr_data), .single_bank(single_bank),
        .prg_lo_addr(prg_lo_addr), .prg_lo_data(prg_lo_data),
        .prg_hi_addr(prg_hi_addr), .prg_hi_data(prg_hi_data),
        .rd_data(rd_data), .rd_valid(rd_valid), .bad_access(bad_access),
        .dma_kick(dma_kick), .dma_page(dma_page)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        rd_en = 0; wr_en = 0; word_rd = 0;
    endtask

    // drive at a falling edge, registered outputs are sampled at the next falling edge
    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1; rd_en = 0; word_rd = 0;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic bus_rd(input logic [15:0] a, input logic w);
        addr = a; rd_en = 1; wr_en = 0; word_rd = w;
        @(negedge clk);
        rd_en = 0; word_rd = 0;
    endtask

    task automatic t_reset();
        check("R1 rd_valid", {15'd0, rd_valid}, 16'd0);
        check("R1 bad_access", {15'd0, bad_access}, 16'd0);
        check("R1 dma_kick", {15'd0, dma_kick}, 16'd0);
        check("R1 dma_page", {8'd0, dma_page}, 16'd0);
        check("R1 rd_data", rd_data, 16'd0);
    endtask

    task automatic t_ram_mirror();
        bus_wr(16'h0123, 8'hA5);
        bus_rd(16'h0923, 0); check("R2 mirror1", rd_data, 16'h00A5);
        check("R11 valid", {15'd0, rd_valid}, 16'd1);
        bus_rd(16'h1123, 0); check("R2 mirror2", rd_data, 16'h00A5);
        bus_rd(16'h1923, 0); check("R2 mirror3", rd_data, 16'h00A5);
        bus_wr(16'h17FF, 8'h3C);
        bus_rd(16'h07FF, 0); check("R2 top alias", rd_data, 16'h003C);
    endtask

    task automatic t_preg();
        bus_wr(16'h2003, 8'h77);
        bus_rd(16'h3FFB, 0); check("R3 reg3 alias", rd_data, 16'h0077);
        bus_wr(16'h200E, 8'h11);
        bus_rd(16'h2006, 0); check("R3 reg6", rd_data, 16'h0011);
        bus_rd(16'h2003, 0); check("R3 reg3 kept", rd_data, 16'h0077);
    endtask

    task automatic t_io();
        bus_wr(16'h4015, 8'hFF);
        bus_rd(16'h4015, 0); check("R4 io after write", rd_data, 16'h0000);
        check("R4 no flag", {15'd0, bad_access}, 16'd0);
        bus_rd(16'h401F, 0); check("R4 io top", rd_data, 16'h0000);
    endtask

    task automatic t_dma();
        bus_wr(16'h4014, 8'hC7);
        check("R5 kick", {15'd0, dma_kick}, 16'd1);
        check("R5 page", {8'd0, dma_page}, 16'h00C7);
        idle();
        check("R5 kick drop", {15'd0, dma_kick}, 16'd0);
        bus_wr(16'h0200, 8'h01);
        check("R5 page held", {8'd0, dma_page}, 16'h00C7);
        check("R5 no kick", {15'd0, dma_kick}, 16'd0);
    endtask

    task automatic t_hole();
        bus_rd(16'h4020, 0); check("R6 hole low", {15'd0, bad_access}, 16'd1);
        bus_rd(16'h5FFF, 0); check("R6 hole high", {15'd0, bad_access}, 16'd1);
        bus_wr(16'h5000, 8'h42); check("R6 hole write", {15'd0, bad_access}, 16'd1);
        bus_rd(16'h0123, 0); check("R6 clear", {15'd0, bad_access}, 16'd0);
        bus_rd(16'h401F, 1); check("R6 word into hole", {15'd0, bad_access}, 16'd1);
    endtask

    task automatic t_cram();
        bus_wr(16'h6000, 8'h99); check("R7 write no flag", {15'd0, bad_access}, 16'd0);
        bus_rd(16'h6000, 0); check("R7 read zero", rd_data, 16'h0000);
        check("R7 read no flag", {15'd0, bad_access}, 16'd0);
    endtask

    task automatic t_rom();
        single_bank = 0;
        bus_rd(16'h8000, 0); check("R8 rom base", rd_data, {8'd0, rom_byte(15'h0000)});
        bus_rd(16'hC123, 0); check("R8 rom upper", rd_data, {8'd0, rom_byte(15'h4123)});
        single_bank = 1;
        bus_rd(16'hC123, 0); check("R8 one bank fold", rd_data, {8'd0, rom_byte(15'h0123)});
        single_bank = 0;
    endtask

    task automatic t_rom_wr();
        bus_wr(16'h9000, 8'h00); check("R9 flag", {15'd0, bad_access}, 16'd1);
        bus_rd(16'h9000, 0); check("R9 rom intact", rd_data, {8'd0, rom_byte(15'h1000)});
    endtask

    task automatic t_word();
        bus_wr(16'h07FF, 8'h12);
        bus_wr(16'h0000, 8'h34);
        bus_rd(16'h07FF, 1); check("R10 ram wrap", rd_data, 16'h3412);
        bus_rd(16'hFFFF, 1); check("R10 top wrap", rd_data, {8'h34, rom_byte(15'h7FFF)});
        bus_rd(16'h1FFF, 1); check("R10 seam", rd_data, 16'h0012);
    endtask

    task automatic t_latency();
        bus_rd(16'h0000, 0);
        idle();
        check("R11 valid drop", {15'd0, rd_valid}, 16'd0);
        check("R11 data held", rd_data, 16'h0034);
        addr = 16'h0050; wr_data = 8'hEE; wr_en = 1; rd_en = 1; word_rd = 0;
        @(negedge clk);
        wr_en = 0; rd_en = 0;
        check("R12 no valid", {15'd0, rd_valid}, 16'd0);
        check("R12 data unchanged", rd_data, 16'h0034);
        bus_rd(16'h0050, 0); check("R12 write done", rd_data, 16'h00EE);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1; addr = 0; rd_en = 0; wr_en = 0; word_rd = 0; wr_data = 0; single_bank = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_ram_mirror();
        t_preg();
        t_io();
        t_dma();
        t_hole();
        t_cram();
        t_rom();
        t_rom_wr();
        t_word();
        t_latency();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule